// File: doc/BRIEF.md
# Keyed Mode Register with Status Companion

This block is a small slice of a register file that sits on a byte-wide register bus. It holds two registers: a mode register and a status register beside it. The status register follows an external status word and is read-only. The mode register is never loaded directly. Each write combines three values with XOR: the written byte, the value the mode register holds now, and the value the status register holds now. The result becomes the new mode value.

To place a chosen value in the mode register, software first reads both registers. It then XORs the two read values with the value it wants and writes that result to the mode address. Two bits of the mode register leave the block as control outputs. One enables double-data-rate output. The other selects the slow or the fast range of a clock generator. The other six bits are stored and can be read back, but they drive nothing.

Reads are registered. Read data appears one clock after the read strobe and then stays until the next read.

Top module: `keyed_cfg_regs`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the mode register is 0x00, `ddr_en` is 0, `clk_range_fast` is 0 and `bus_rdata` is 0x00.
- R2: When `bus_wr` is high with `bus_addr` = 0x74 at a rising clock edge, the mode register loads `bus_wdata` XOR the old mode value XOR the status register value, both taken in that same cycle.
- R3: If software reads 0x74 and 0x75, XORs the two results with a desired byte and writes that to 0x74 while the status input is steady, the mode register then holds exactly the desired byte.
- R4: `ddr_en` equals mode bit 0. `clk_range_fast` equals mode bit 1, where 1 means fast and 0 means slow. Mode bits 7:2 are stored and read back but drive no output.
- R5: When `bus_rd` is high with `bus_addr` = 0x74 at a clock edge, `bus_rdata` shows the decoded mode value held before that edge, one cycle after the strobe.
- R6: The status register loads `status_in` at every clock edge out of reset. A read of 0x75 returns that register's value, one cycle after the strobe.
- R7: A bus write to 0x75 has no effect: neither the status register nor the mode register changes.
- R8: A write to any address other than 0x74 leaves the mode register unchanged. A read of any address other than 0x74 or 0x75 returns 0x00.
- R9: Back-to-back writes to 0x74 chain: each write decodes against the mode value that the write before it left.
- R10: `bus_rdata` holds its value in any cycle where `bus_rd` is low. A read and a write to 0x74 in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| status_in | input | 8 | External status word, sampled every cycle |
| ddr_en | output | 1 | Double-data-rate output enable (mode bit 0) |
| clk_range_fast | output | 1 | Clock-generator range: 1 = fast, 0 = slow (mode bit 1) |

## Verification
Every result in this block arrives one register stage after its cause:
- A mode write shows on `ddr_en` and `clk_range_fast` one edge after the strobe.
- Read data shows on `bus_rdata` one edge after the strobe.
- A new `status_in` value reaches the status register at the next edge. A read of 0x75 therefore returns the value of `status_in` from the cycle before the read strobe.

The bench drives each operation at a falling edge. It advances its reference model at the rising edge, using only the values from before that edge. It compares the outputs a quarter period after the rising edge. This way each check lands on the cycle where the result is due, and any extra or missing stage in the design shows up as a mismatch.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    // Which register a bus address selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    // Positions of the mode fields that leave the block
    localparam int unsigned MODE_DDR_BIT   = 0;
    localparam int unsigned MODE_RANGE_BIT = 1;

    // Value the mode register takes after a keyed write
    function automatic logic [7:0] keyed_next(
        input logic [7:0] wr_byte,
        input logic [7:0] cur_mode,
        input logic [7:0] cur_stat
    );
        return wr_byte ^ cur_mode ^ cur_stat;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]  MODE_ADDR = 8'h74,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 8'h75
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == MODE_ADDR)      sel = SEL_MODE;
        else if (addr == STAT_ADDR) sel = SEL_STAT;
        else                        sel = SEL_NONE;
    end
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] stat_val
);
    typedef struct packed {
        logic [DATA_W-1:0] stat;
    } stat_state_t;

    stat_state_t st_d, st_q;

    // The bus has no path into this register; it only follows status_in.
    always_comb begin
        st_d      = st_q;
        st_d.stat = status_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_val = st_q.stat;
endmodule

// File: rtl/cfg_keyed_reg.sv
module cfg_keyed_reg
    import cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] stat_val,
    output logic [DATA_W-1:0] mode_val
);
    typedef struct packed {
        logic [DATA_W-1:0] mode;
    } mode_state_t;

    mode_state_t md_d, md_q;

    always_comb begin
        md_d = md_q;
        if (wr_en) begin
            // Each bit slice follows the same keyed update
            for (int unsigned b = 0; b < DATA_W; b += 8) begin
                md_d.mode[b +: 8] = keyed_next(wr_data[b +: 8],
                                               md_q.mode[b +: 8],
                                               stat_val[b +: 8]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) md_q <= '0;
        else        md_q <= md_d;
    end

    assign mode_val = md_q.mode;
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
    import cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] mode_val,
    input  logic [DATA_W-1:0] stat_val,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            unique case (sel)
                SEL_MODE: rd_d.rdata = mode_val;
                SEL_STAT: rd_d.rdata = stat_val;
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.rdata;
endmodule

// File: rtl/keyed_cfg_regs.sv
module keyed_cfg_regs
    import cfg_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        DATA_W    = 8,
    parameter logic [ADDR_W-1:0]  MODE_ADDR = 8'h74,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 8'h75
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] status_in,
    output logic              ddr_en,
    output logic              clk_range_fast
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] mode_val;
    logic [DATA_W-1:0] stat_val;
    logic              mode_wr;

    cfg_addr_decode #(
        .ADDR_W   (ADDR_W),
        .MODE_ADDR(MODE_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    assign mode_wr = bus_wr && (sel == SEL_MODE);

    cfg_status_reg #(.DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_in(status_in),
        .stat_val (stat_val)
    );

    cfg_keyed_reg #(.DATA_W(DATA_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_data (bus_wdata),
        .stat_val(stat_val),
        .mode_val(mode_val)
    );

    cfg_read_port #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .sel     (sel),
        .mode_val(mode_val),
        .stat_val(stat_val),
        .rdata   (bus_rdata)
    );

    assign ddr_en         = mode_val[MODE_DDR_BIT];
    assign clk_range_fast = mode_val[MODE_RANGE_BIT];
endmodule

// File: rtl/keyed_cfg_regs_chk.sv
module keyed_cfg_regs_chk #(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        DATA_W    = 8,
    parameter logic [ADDR_W-1:0]  MODE_ADDR = 8'h74,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 8'h75
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] status_in,
    input logic              ddr_en,
    input logic              clk_range_fast,
    input logic [DATA_W-1:0] mode_val,
    input logic [DATA_W-1:0] stat_val
);
    // R2
    keyed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == MODE_ADDR) |=>
            mode_val == ($past(bus_wdata) ^ $past(mode_val) ^ $past(stat_val)));

    // R7
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_ADDR) |=> $stable(mode_val));

    // R8
    other_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == MODE_ADDR) |=> $stable(mode_val));

    // R4
    outputs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == MODE_ADDR) |=> ($stable(ddr_en) && $stable(clk_range_fast)));

    // R5
    mode_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == MODE_ADDR) |=> bus_rdata == $past(mode_val));

    // R6
    stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stat_val == $past(status_in));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind keyed_cfg_regs keyed_cfg_regs_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MODE_ADDR(MODE_ADDR),
    .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .status_in     (status_in),
    .ddr_en        (ddr_en),
    .clk_range_fast(clk_range_fast),
    .mode_val      (mode_val),
    .stat_val      (stat_val)
);

// File: tb/tb_keyed_cfg_regs.sv
module tb_keyed_cfg_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_MODE = 8'h74;
    localparam logic [7:0] A_STAT = 8'h75;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr, bus_wdata, bus_rdata, status_in;
    logic       bus_wr, bus_rd, ddr_en, clk_range_fast;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // Reference model state
    logic [7:0] m_mode, m_stat, m_rdata;

    keyed_cfg_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .status_in(status_in), .ddr_en(ddr_en), .clk_range_fast(clk_range_fast)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_mode(input logic [7:0] wd, input logic [7:0] mode,
                                            input logic [7:0] stat);
        return wd ^ mode ^ stat;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [7:0] mode,
                                            input logic [7:0] stat);
        if (a == A_MODE) return mode;
        if (a == A_STAT) return stat;
        return 8'h00;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", what, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, update the model at the rising
    // edge from pre-edge values, compare a quarter period later.
    task automatic step(input logic [7:0] a, input logic [7:0] wd, input logic w,
                        input logic r, input logic [7:0] st, input string tag);
        logic [7:0] nm, nr;
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_wr = w; bus_rd = r; status_in = st;
        @(posedge clk);
        nm = m_mode;
        if (w && a == A_MODE) nm = exp_mode(wd, m_mode, m_stat);
        nr = m_rdata;
        if (r) nr = exp_read(a, m_mode, m_stat);
        m_mode = nm; m_stat = st; m_rdata = nr;
        #(CLK_PERIOD/4);
        check(bus_rdata, m_rdata, {tag, " rdata"});
        check({7'd0, ddr_en}, {7'd0, m_mode[0]}, {tag, " R4 ddr_en"});
        check({7'd0, clk_range_fast}, {7'd0, m_mode[1]}, {tag, " R4 clk_range_fast"});
    endtask

    task automatic read_reg(input logic [7:0] a, input logic [7:0] st, input string tag,
                            output logic [7:0] val);
        step(a, 8'h00, 1'b0, 1'b1, st, tag);
        val = bus_rdata;
    endtask

    task automatic keyed_set(input logic [7:0] want, input logic [7:0] st);
        logic [7:0] mv, sv;
        read_reg(A_MODE, st, "R3 pre-read mode", mv);
        read_reg(A_STAT, st, "R3 pre-read stat", sv);
        step(A_MODE, want ^ mv ^ sv, 1'b1, 1'b0, st, "R3 encoded write");
        read_reg(A_MODE, st, "R3 readback", mv);
        check(mv, want, "R3 mode lands on desired value");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5512));
        rst_n = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0;
        bus_rd = 1'b0; status_in = 8'h3C;
        m_mode = 8'h00; m_stat = 8'h00; m_rdata = 8'h00;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset state
        check(bus_rdata, 8'h00, "R1 rdata in reset");
        check({7'd0, ddr_en}, 8'h00, "R1 ddr_en in reset");
        check({7'd0, clk_range_fast}, 8'h00, "R1 range in reset");
        @(negedge clk);
        rst_n = 1'b1;
        status_in = 8'h00;
        step(A_MODE, 8'h00, 1'b0, 1'b1, 8'h00, "R1 first read after reset");

        // R6: status capture and read-back
        step(8'h00, 8'h00, 1'b0, 1'b0, 8'hA5, "R6 load status");
        step(A_STAT, 8'h00, 1'b0, 1'b1, 8'hA5, "R6 read status");
        // R2: raw write decodes against mode and status
        step(A_MODE, 8'h0F, 1'b1, 1'b0, 8'hA5, "R2 raw write");
        step(A_MODE, 8'h00, 1'b0, 1'b1, 8'hA5, "R2/R5 read mode");
        // R7: write to status address ignored
        step(A_STAT, 8'hFF, 1'b1, 1'b0, 8'hA5, "R7 write status");
        step(A_STAT, 8'h00, 1'b0, 1'b1, 8'hA5, "R7 status unchanged");
        step(A_MODE, 8'h00, 1'b0, 1'b1, 8'hA5, "R7 mode unchanged");
        // R8: other addresses
        step(8'h10, 8'h77, 1'b1, 1'b1, 8'hA5, "R8 write/read other addr");
        step(A_MODE, 8'h00, 1'b0, 1'b1, 8'hA5, "R8 mode unchanged");
        // R3: encoded writes for each range/DDR combination
        keyed_set(8'h00, 8'h5A);
        keyed_set(8'h01, 8'h5A);
        keyed_set(8'h02, 8'hC3);
        keyed_set(8'h03, 8'hC3);
        keyed_set(8'hFC, 8'h00);
        // R9: back-to-back chained writes
        step(A_MODE, 8'h11, 1'b1, 1'b0, 8'h22, "R9 chain 1");
        step(A_MODE, 8'h44, 1'b1, 1'b0, 8'h22, "R9 chain 2");
        step(A_MODE, 8'h81, 1'b1, 1'b0, 8'h99, "R9 chain 3");
        step(A_MODE, 8'h00, 1'b0, 1'b1, 8'h99, "R9 read after chain");
        // R10: hold without read, read+write same cycle
        step(A_MODE, 8'h00, 1'b0, 1'b0, 8'h99, "R10 hold");
        step(A_MODE, 8'h5E, 1'b1, 1'b1, 8'h99, "R10 rd+wr same cycle");
        step(A_MODE, 8'h00, 1'b0, 1'b1, 8'h99, "R10 read new value");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            int unsigned pick;
            pick = $urandom_range(0, 3);
            a = (pick == 0) ? A_MODE : (pick == 1) ? A_STAT :
                (pick == 2) ? A_MODE : 8'($urandom);
            step(a, 8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                 "R2/R5/R6/R8 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule